// File: doc/BRIEF.md
# External Memory Bus Front End

This block sits between a small 8-bit processor core with a 16-bit address space and the pins of an external memory bus. The core hands it code-fetch requests and external data read or write requests. Each request is a valid/ready handshake. The block runs one bus cycle at a time and returns a one-cycle done pulse. For a fetch or a read, the pulse carries the returned byte.

A strap input is captured while reset is asserted. With the strap high, code fetches below `ROM_BYTES` are answered by an on-chip ROM through a simple request/response port. Fetches at or above that limit go out on the external bus. With the strap low, every fetch goes out on the external bus. Data requests always use the external bus.

An external cycle first places the low address byte on a shared port with the address latch enable high, so an external transparent latch can capture it. The high address byte stays on its own port for the whole cycle. The shared port then turns around: it is released for reads and carries the write byte for writes. One of three active-low strobes is then held low for `STROBE_CYC` clocks: program store enable for fetches, read for data reads, write for data writes.

Back-pressure works as follows. A requester keeps valid and its fields steady until the cycle in which ready is high. Ready is low while a cycle is in progress. Data ready is also low whenever a code request is valid.

Top module: `xbus_front`

## Requirements
- R1: The strap `code_local_en` is sampled on every clock edge while `rst_n` is low and is held unchanged from the release of reset until the next reset.
- R2: With the held strap high and a code address below `ROM_BYTES`, the cycle after acceptance has `rom_req`=1 with `rom_addr` equal to the address. The next cycle has `code_done`=1 with `code_data` equal to the `rom_data` seen during the request cycle. No strobe or `ale` is asserted.
- R3: With the held strap high, a code address at or above `ROM_BYTES` runs an external code cycle.
- R4: With the held strap low, every code address, including address 0, runs an external code cycle.
- R5: An external cycle begins, in the cycle after acceptance, with `ale`=1, `ad_oe`=1 and `ad_o` equal to address bits 7:0. The next cycle has `ale`=0 with the same `ad_o` still driven. `a_hi` carries address bits 15:8 through every cycle of the bus cycle.
- R6: External code cycles drive `psen_n` low for exactly `STROBE_CYC` cycles after the latch cycle, while `rd_n` and `wr_n` stay high.
- R7: External data reads drive `rd_n` low for `STROBE_CYC` cycles with `ad_oe`=0, and never assert `psen_n`.
- R8: External data writes drive `wr_n` low for `STROBE_CYC` cycles with `ad_oe`=1 and `ad_o` equal to the write byte.
- R9: Read data is taken from `ad_i` on the last strobe-low cycle. In the following cycle, the strobe is high again and `code_done` (fetch) or `dat_done` (read, and also write completion) pulses for one cycle with the byte. A write leaves `dat_rdata` unchanged.
- R10: Only one cycle runs at a time. `code_ready` and `dat_ready` are low while busy, and `dat_ready` is low while `code_valid` is high, so a code request wins over a data request made in the same cycle.
- R11: While in reset, `ale`=0, all strobes are high, `ad_oe`=0, `rom_req`=0, both done outputs are 0 and `code_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_local_en | input | 1 | Strap: 1 lets low code addresses use on-chip ROM |
| code_valid | input | 1 | Code fetch request valid |
| code_ready | output | 1 | Code fetch request accepted when high with valid |
| code_addr | input | AW | Code fetch address |
| code_done | output | 1 | One-cycle pulse: fetched byte available |
| code_data | output | DW | Fetched byte |
| dat_valid | input | 1 | Data request valid |
| dat_ready | output | 1 | Data request accepted when high with valid |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_addr | input | AW | Data address |
| dat_wdata | input | DW | Write byte |
| dat_done | output | 1 | One-cycle pulse: data cycle finished |
| dat_rdata | output | DW | Byte returned by the last data read |
| rom_req | output | 1 | On-chip ROM read request |
| rom_addr | output | AW | On-chip ROM address |
| rom_data | input | DW | On-chip ROM byte, valid while `rom_req` is high |
| ad_o | output | DW | Shared port, outgoing address-low or write byte |
| ad_oe | output | 1 | Shared port output enable |
| ad_i | input | DW | Shared port, incoming byte |
| a_hi | output | AW-DW | High address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench builds the block with `ROM_BYTES`=256 and `STROBE_CYC`=2. With the smaller ROM size, the on-chip/off-chip boundary (addresses 0x00FF and 0x0100) is reached with short addresses. The two-cycle strobe exercises both the counting and the last-cycle sampling point. The bench resets a second time with the strap low, so both strap settings are covered. It also changes the strap after reset to show that the held value is what counts.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROM,
    ST_ADDR,
    ST_HOLD,
    ST_STRB
  } xb_state_e;

  typedef enum logic [1:0] {
    K_CODE,
    K_RD,
    K_WR
  } xb_kind_e;

endpackage

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          idle,
  input  logic          code_valid,
  input  logic [AW-1:0] code_addr,
  input  logic          dat_valid,
  input  logic          dat_we,
  input  logic [AW-1:0] dat_addr,
  input  logic [DW-1:0] dat_wdata,
  output logic          code_ready,
  output logic          dat_ready,
  output logic          take,
  output xb_kind_e      take_kind,
  output logic [AW-1:0] take_addr,
  output logic [DW-1:0] take_wdata
);

  // Code requests win; a data request waits while any code request is valid.
  assign code_ready = idle;
  assign dat_ready  = idle && !code_valid;
  assign take       = idle && (code_valid || dat_valid);

  always_comb begin
    if (code_valid) begin
      take_kind  = K_CODE;
      take_addr  = code_addr;
      take_wdata = '0;
    end else begin
      take_kind  = dat_we ? K_WR : K_RD;
      take_addr  = dat_addr;
      take_wdata = dat_wdata;
    end
  end

endmodule

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int ROM_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_in,
  input  xb_kind_e      kind,
  input  logic [AW-1:0] addr,
  output logic          on_chip
);

  localparam logic [AW:0] ROM_LIM = (AW+1)'(ROM_BYTES);

  logic strap_q;

  // Strap follows the pin only while reset is held, then freezes.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  assign on_chip = (kind == K_CODE) && strap_q && ({1'b0, addr} < ROM_LIM);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int STROBE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  xb_kind_e         take_kind,
  input  logic [AW-1:0]    take_addr,
  input  logic [DW-1:0]    take_wdata,
  input  logic             take_onchip,
  input  logic [DW-1:0]    rom_data,
  input  logic [DW-1:0]    ad_i,
  output logic             idle,
  output logic             rom_req,
  output logic [AW-1:0]    rom_addr,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             code_done,
  output logic [DW-1:0]    code_data,
  output logic             dat_done,
  output logic [DW-1:0]    dat_rdata
);

  localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  xb_state_e     state_q;
  xb_kind_e      kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_CODE;
      addr_q    <= '0;
      wd_q      <= '0;
      cnt_q     <= '0;
      code_done <= 1'b0;
      code_data <= '0;
      dat_done  <= 1'b0;
      dat_rdata <= '0;
    end else begin
      code_done <= 1'b0;
      dat_done  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (take) begin
          kind_q  <= take_kind;
          addr_q  <= take_addr;
          wd_q    <= take_wdata;
          state_q <= take_onchip ? ST_ROM : ST_ADDR;
        end
        ST_ROM: begin
          code_done <= 1'b1;
          code_data <= rom_data;
          state_q   <= ST_IDLE;
        end
        ST_ADDR: state_q <= ST_HOLD;
        ST_HOLD: begin
          cnt_q   <= '0;
          state_q <= ST_STRB;
        end
        ST_STRB: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            if (kind_q == K_CODE) begin
              code_done <= 1'b1;
              code_data <= ad_i;
            end else begin
              dat_done <= 1'b1;
              if (kind_q == K_RD) dat_rdata <= ad_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic strobing;
  assign strobing = (state_q == ST_STRB);
  assign idle     = (state_q == ST_IDLE);
  assign rom_req  = (state_q == ST_ROM);
  assign rom_addr = addr_q;
  assign ale      = (state_q == ST_ADDR);
  assign ad_oe    = (state_q == ST_ADDR) || (state_q == ST_HOLD) ||
                    (strobing && kind_q == K_WR);
  assign ad_o     = strobing ? wd_q : addr_q[DW-1:0];
  assign a_hi     = addr_q[AW-1:DW];
  assign psen_n   = !(strobing && kind_q == K_CODE);
  assign rd_n     = !(strobing && kind_q == K_RD);
  assign wr_n     = !(strobing && kind_q == K_WR);

endmodule

// File: rtl/xbus_front.sv
module xbus_front
  import xbus_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int ROM_BYTES  = 4096,
  parameter int STROBE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_local_en,
  input  logic             code_valid,
  output logic             code_ready,
  input  logic [AW-1:0]    code_addr,
  output logic             code_done,
  output logic [DW-1:0]    code_data,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic             dat_we,
  input  logic [AW-1:0]    dat_addr,
  input  logic [DW-1:0]    dat_wdata,
  output logic             dat_done,
  output logic [DW-1:0]    dat_rdata,
  output logic             rom_req,
  output logic [AW-1:0]    rom_addr,
  input  logic [DW-1:0]    rom_data,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_i,
  output logic [AW-DW-1:0] a_hi,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n
);

  logic          idle;
  logic          take;
  xb_kind_e      take_kind;
  logic [AW-1:0] take_addr;
  logic [DW-1:0] take_wdata;
  logic          take_onchip;

  xbus_arbiter #(.AW(AW), .DW(DW)) u_arb (
    .idle       (idle),
    .code_valid (code_valid),
    .code_addr  (code_addr),
    .dat_valid  (dat_valid),
    .dat_we     (dat_we),
    .dat_addr   (dat_addr),
    .dat_wdata  (dat_wdata),
    .code_ready (code_ready),
    .dat_ready  (dat_ready),
    .take       (take),
    .take_kind  (take_kind),
    .take_addr  (take_addr),
    .take_wdata (take_wdata)
  );

  xbus_route #(.AW(AW), .ROM_BYTES(ROM_BYTES)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_in (code_local_en),
    .kind     (take_kind),
    .addr     (take_addr),
    .on_chip  (take_onchip)
  );

  xbus_seq #(.AW(AW), .DW(DW), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .take_kind   (take_kind),
    .take_addr   (take_addr),
    .take_wdata  (take_wdata),
    .take_onchip (take_onchip),
    .rom_data    (rom_data),
    .ad_i        (ad_i),
    .idle        (idle),
    .rom_req     (rom_req),
    .rom_addr    (rom_addr),
    .ad_o        (ad_o),
    .ad_oe       (ad_oe),
    .a_hi        (a_hi),
    .ale         (ale),
    .psen_n      (psen_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .code_done   (code_done),
    .code_data   (code_data),
    .dat_done    (dat_done),
    .dat_rdata   (dat_rdata)
  );

endmodule

// File: rtl/xbus_checks.sv
module xbus_checks (
  input logic clk,
  input logic rst_n,
  input logic code_ready,
  input logic dat_ready,
  input logic code_done,
  input logic dat_done,
  input logic rom_req,
  input logic ad_oe,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n
);

  a_r6_psen_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));

  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r8_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  a_r5_latch_then_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && ad_oe && psen_n && rd_n && wr_n));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || rom_req || !psen_n || !rd_n || !wr_n) |-> (!code_ready && !dat_ready));

  a_r2_rom_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |-> (psen_n && rd_n && wr_n && !ale));

  a_r9_code_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    code_done |-> ($past(rom_req) || !$past(psen_n)));

  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_done && dat_done));

endmodule

bind xbus_front xbus_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .code_ready (code_ready),
  .dat_ready  (dat_ready),
  .code_done  (code_done),
  .dat_done   (dat_done),
  .rom_req    (rom_req),
  .ad_oe      (ad_oe),
  .ale        (ale),
  .psen_n     (psen_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n)
);

// File: tb/sim_xbus_front.sv
`timescale 1ns/1ps
module sim_xbus_front;

  localparam int ROMB = 256;
  localparam int SC   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        code_valid = 1'b0;
  logic [15:0] code_addr = '0;
  logic        dat_valid = 1'b0;
  logic        dat_we = 1'b0;
  logic [15:0] dat_addr = '0;
  logic [7:0]  dat_wdata = '0;
  logic        code_ready, dat_ready, code_done, dat_done;
  logic [7:0]  code_data, dat_rdata;
  logic        rom_req;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data;
  logic [7:0]  ad_o, ad_i, a_hi;
  logic        ad_oe, ale, psen_n, rd_n, wr_n;

  always #5 clk = ~clk;

  xbus_front #(.AW(16), .DW(8), .ROM_BYTES(ROMB), .STROBE_CYC(SC)) u0 (
    .clk(clk), .rst_n(rst_n), .code_local_en(strap),
    .code_valid(code_valid), .code_ready(code_ready), .code_addr(code_addr),
    .code_done(code_done), .code_data(code_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_we(dat_we),
    .dat_addr(dat_addr), .dat_wdata(dat_wdata),
    .dat_done(dat_done), .dat_rdata(dat_rdata),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_data(rom_data),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .a_hi(a_hi),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  function automatic logic [7:0] rom_pat(input logic [15:0] a);
    return ~a[7:0] ^ a[15:8];
  endfunction
  function automatic logic [7:0] code_pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] data_pat(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h71;
  endfunction

  // External memory with its own low-address latch
  logic [7:0] lat_lo = '0;
  always @(negedge ale) lat_lo = ad_o;
  assign rom_data = rom_pat(rom_addr);
  assign ad_i = !psen_n ? code_pat({a_hi, lat_lo}) :
                !rd_n   ? data_pat({a_hi, lat_lo}) : 8'hEE;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase name plus counters
  int          mst = 0;   // 0 idle, 1 rom, 2 addr, 3 hold, 4 strobe
  int          mcnt = 0;
  int          mk = 0;    // 0 code, 1 read, 2 write
  logic [15:0] maddr = '0;
  logic [7:0]  mwd = '0;
  bit          m_strap = 0;
  bit          mcd = 0, mdd = 0;
  logic [7:0]  mcdata = '0, mddata = '0;
  bit          acc_c = 0, acc_d = 0;

  always @(posedge clk) begin
    acc_c = 0; acc_d = 0;
    if (!rst_n) begin
      m_strap = strap; mst = 0; mcd = 0; mdd = 0; mcdata = '0; mddata = '0;
    end else begin
      mcd = 0; mdd = 0;
      case (mst)
        0: if (code_valid) begin
             acc_c = 1; mk = 0; maddr = code_addr;
             mst = (m_strap && code_addr < ROMB) ? 1 : 2;
           end else if (dat_valid) begin
             acc_d = 1; mk = dat_we ? 2 : 1; maddr = dat_addr; mwd = dat_wdata; mst = 2;
           end
        1: begin mcd = 1; mcdata = rom_pat(maddr); mst = 0; end
        2: mst = 3;
        3: begin mst = 4; mcnt = 0; end
        default: if (mcnt == SC - 1) begin
             mst = 0;
             if (mk == 0) begin mcd = 1; mcdata = code_pat(maddr); end
             else begin mdd = 1; if (mk == 1) mddata = data_pat(maddr); end
           end else mcnt++;
      endcase
    end
  end

  // Cycle compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !rom_req && !code_done
          && !dat_done && code_ready, "R11", "reset outputs",
          {ale, psen_n, rd_n, wr_n, ad_oe, rom_req, code_done, dat_done, code_ready},
          9'b0_111_0_0_0_0_1);
    end else begin
      chk(ale == (mst == 2), "R5", "ale", ale, mst == 2);
      chk(ad_oe == (mst == 2 || mst == 3 || (mst == 4 && mk == 2)), "R7", "ad_oe", ad_oe,
          mst == 2 || mst == 3 || (mst == 4 && mk == 2));
      if (mst == 2 || mst == 3) chk(ad_o == maddr[7:0], "R5", "ad_o addr", ad_o, maddr[7:0]);
      if (mst >= 2) chk(a_hi == maddr[15:8], "R5", "a_hi", a_hi, maddr[15:8]);
      if (mst == 4 && mk == 2) chk(ad_o == mwd, "R8", "ad_o wdata", ad_o, mwd);
      chk(psen_n == !(mst == 4 && mk == 0), "R6", "psen_n", psen_n, !(mst == 4 && mk == 0));
      chk(rd_n == !(mst == 4 && mk == 1), "R7", "rd_n", rd_n, !(mst == 4 && mk == 1));
      chk(wr_n == !(mst == 4 && mk == 2), "R8", "wr_n", wr_n, !(mst == 4 && mk == 2));
      chk(rom_req == (mst == 1), "R2", "rom_req", rom_req, mst == 1);
      if (mst == 1) chk(rom_addr == maddr, "R2", "rom_addr", rom_addr, maddr);
      chk(code_done == mcd, "R9", "code_done", code_done, mcd);
      chk(dat_done == mdd, "R9", "dat_done", dat_done, mdd);
      if (mcd) chk(code_data == mcdata, "R9", "code_data", code_data, mcdata);
      chk(dat_rdata == mddata, "R9", "dat_rdata", dat_rdata, mddata);
      chk(code_ready == (mst == 0), "R10", "code_ready", code_ready, mst == 0);
      chk(dat_ready == (mst == 0 && !code_valid), "R10", "dat_ready", dat_ready,
          mst == 0 && !code_valid);
    end
  end

  // Write seen by the external memory
  logic [15:0] w_addr = '0;
  logic [7:0]  w_data = '0;
  always @(negedge clk) if (rst_n && !wr_n) begin w_addr = {a_hi, lat_lo}; w_data = ad_o; end

  task automatic fetch(input logic [15:0] a);
    @(negedge clk); code_valid = 1; code_addr = a;
    do begin @(posedge clk); #1; end while (!acc_c);
    code_valid = 0;
  endtask

  task automatic dreq(input bit we, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); dat_valid = 1; dat_we = we; dat_addr = a; dat_wdata = d;
    do begin @(posedge clk); #1; end while (!acc_d);
    dat_valid = 0;
  endtask

  task automatic settle();
    do @(negedge clk); while (mst != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk); rst_n = 0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    strap = 0;                 // R1: change after reset must have no effect
    fetch(16'h0010); settle(); // R2 on-chip
    fetch(16'h00FF); settle(); // R2 last on-chip byte
    fetch(16'h0100); settle(); // R3 first external address
    fetch(16'h8123); settle(); // R3, R6
    dreq(0, 16'h1234, 8'h00); settle();  // R7, R9
    dreq(1, 16'h4321, 8'hA5); settle();  // R8
    chk(w_addr == 16'h4321, "R8", "write address", w_addr, 16'h4321);
    chk(w_data == 8'hA5, "R8", "write data", w_data, 8'hA5);
    // R10: same-cycle code and data, code goes first
    @(negedge clk);
    code_valid = 1; code_addr = 16'h0300;
    dat_valid = 1; dat_we = 0; dat_addr = 16'h0042;
    do begin @(posedge clk); #1; end while (!acc_c);
    chk(acc_c && !acc_d, "R10", "code priority", acc_d, 0);
    code_valid = 0;
    do begin @(posedge clk); #1; end while (!acc_d);
    dat_valid = 0;
    settle();
    // R10: data arriving during an on-chip fetch waits
    fetch(16'h0020);
    dreq(0, 16'h7F7F, 8'h00); settle();
    // R4: strap low, low addresses go external
    do_reset(0);
    fetch(16'h0010); settle();
    fetch(16'h0000); settle();
    fetch(16'h00FF); settle();
    dreq(1, 16'h0001, 8'h3C); settle();
    chk(w_data == 8'h3C, "R8", "write data 2", w_data, 8'h3C);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule